// File: doc/BRIEF.md
# Tunable Inductor-Current Estimator

This block produces one estimate of the average inductor current of a digitally controlled buck converter for every switching cycle. It never samples the switching node. Instead it rebuilds the cycle-average inductor voltage from three values the control loop already holds:

- the duty-ratio command;
- the output-voltage code, which is fresh every cycle;
- an input-voltage code, which arrives only about once per ten cycles and is held in between.

The average voltage then drives a first-order IIR section. That section is derived from the inductor's L/RL model by a bilinear transform. Its recursion is `i[n] = c1*i[n-1] + c2*g*(v[n] + v[n-1])`, where `g` stands for the 1/RL gain.

A separate calibration block writes `c1`, `c2` and `g` through plain input ports while the filter runs. This lets it retune the time constant and the scale without a reset. The block takes a snapshot of the coefficients at each cycle strobe, so a write that lands while an estimate is being computed never corrupts that estimate.

Top module: `ind_cur_est`

## Requirements
- R1: A synchronous active-high reset clears the estimate, the valid flag, the filter state (previous voltage and previous estimate) and the held input-voltage sample to zero.
- R2: The input-voltage code is captured only when `vin_load` is high and is held otherwise. A sample presented in the same clock as `cyc_strobe` is used for that cycle's estimate.
- R3: The average inductor voltage is `floor(duty_cmd * vin / 2^DUTY_W) - vout_code`, a signed value with `duty_cmd` read as an unsigned fraction of full scale (255 of 256 at most with DUTY_W=8).
- R4: The estimate follows `i[n] = c1*i[n-1] + c2*g*(v[n]+v[n-1])`. Here `c1` and `c2` are signed with COEF_FRAC=14 fraction bits, `g` is signed with GAIN_FRAC=8 fraction bits, and `i` and `v` are integer codes.
- R5: The exact result is rounded by adding one half LSB and then taking the floor: +0.5 becomes 1 and -0.5 becomes 0.
- R6: The rounded result saturates to the signed EST_W range, from -32768 to 32767 with the defaults.
- R7: `est_valid` is a one-clock pulse exactly two clocks after each `cyc_strobe`. `est_cur` changes only in that clock and holds otherwise.
- R8: The coefficient values sampled in the `cyc_strobe` clock are the ones used for that cycle's estimate. Changing the ports afterwards does not affect that estimate.
- R9: New coefficient values written without a reset take effect at the next `cyc_strobe`, and the filter state is carried across the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_strobe | input | 1 | One pulse per switching cycle; duty and output voltage are valid |
| duty_cmd | input | DUTY_W | Duty-ratio command, unsigned fraction of full scale |
| vout_code | input | VCODE_W | Output-voltage code for this cycle |
| vin_load | input | 1 | Load a new input-voltage sample |
| vin_code | input | VCODE_W | Input-voltage code |
| coef_fb | input | COEF_W | c1, feedback coefficient, signed Q with COEF_FRAC fraction bits |
| coef_in | input | COEF_W | c2, input coefficient, signed Q with COEF_FRAC fraction bits |
| gain_g | input | GAIN_W | 1/RL gain, signed Q with GAIN_FRAC fraction bits |
| est_valid | output | 1 | New estimate pulse |
| est_cur | output | EST_W | Signed current estimate |

## Verification
A held input sample that is lost or overwritten shows up as a wrong voltage in the very next estimate. The bench exposes this by driving junk on `vin_code` whenever the load flag is low.

Errors in the filter state (previous voltage or previous estimate) appear in the estimate one cycle later. The bench makes these visible by setting `c1` to zero, so each output equals the sum of two average voltages and can be checked against a closed form. With random coefficients the same errors compound over the following cycles.

A coefficient snapshot taken at the wrong moment is caught at once. The bench changes the ports in the clock between the strobe and the result.

// File: rtl/ind_est_pkg.sv
package ind_est_pkg;
  localparam int unsigned DEF_DUTY_W    = 8;
  localparam int unsigned DEF_VCODE_W   = 10;
  localparam int unsigned DEF_COEF_W    = 16;
  localparam int unsigned DEF_COEF_FRAC = 14;
  localparam int unsigned DEF_GAIN_W    = 16;
  localparam int unsigned DEF_GAIN_FRAC = 8;
  localparam int unsigned DEF_EST_W     = 16;
endpackage

// File: rtl/est_vin_hold.sv
module est_vin_hold #(
  parameter int unsigned VCODE_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vin_load,
  input  logic [VCODE_W-1:0] vin_code,
  output logic [VCODE_W-1:0] vin_eff
);
  logic [VCODE_W-1:0] vin_held;

  // a sample arriving with the load flag is usable in the same clock
  assign vin_eff = vin_load ? vin_code : vin_held;

  always_ff @(posedge clk) begin
    if (rst) vin_held <= '0;
    else if (vin_load) vin_held <= vin_code;
  end

  assert_vin_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !vin_load |=> $stable(vin_held));
  assert_vin_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vin_held == '0));
endmodule

// File: rtl/est_avg_volt.sv
module est_avg_volt #(
  parameter int unsigned DUTY_W  = 8,
  parameter int unsigned VCODE_W = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      strobe,
  input  logic [DUTY_W-1:0]         duty,
  input  logic [VCODE_W-1:0]        vin_eff,
  input  logic [VCODE_W-1:0]        vout_code,
  output logic signed [VCODE_W:0]   vl_avg,
  output logic                      vl_valid
);
  localparam int unsigned PROD_W = DUTY_W + VCODE_W;

  logic [PROD_W-1:0]       prod;
  logic [VCODE_W-1:0]      on_part;
  logic signed [VCODE_W:0] diff;

  // full-width product, then drop the duty fraction bits
  assign prod    = PROD_W'(duty) * PROD_W'(vin_eff);
  assign on_part = VCODE_W'(prod >> DUTY_W);
  assign diff    = $signed({1'b0, on_part}) - $signed({1'b0, vout_code});

  always_ff @(posedge clk) begin
    if (rst) begin
      vl_avg   <= '0;
      vl_valid <= 1'b0;
    end else begin
      vl_valid <= strobe;
      if (strobe) vl_avg <= diff;
    end
  end

  assert_avg_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(vl_avg));
  assert_avg_follow_R7: assert property (@(posedge clk) disable iff (rst)
    strobe |=> vl_valid);
endmodule

// File: rtl/est_iir_core.sv
module est_iir_core #(
  parameter int unsigned IN_W      = 11,
  parameter int unsigned COEF_W    = 16,
  parameter int unsigned COEF_FRAC = 14,
  parameter int unsigned GAIN_W    = 16,
  parameter int unsigned GAIN_FRAC = 8,
  parameter int unsigned EST_W     = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [IN_W-1:0]   x_in,
  input  logic signed [COEF_W-1:0] coef_fb,
  input  logic signed [COEF_W-1:0] coef_in,
  input  logic signed [GAIN_W-1:0] gain_g,
  output logic                     est_valid,
  output logic signed [EST_W-1:0]  est_out
);
  localparam int unsigned SUM_W = IN_W + 1;
  localparam int unsigned SCL_W = SUM_W + GAIN_W;
  localparam int unsigned FWD_W = SCL_W + COEF_W;
  localparam int unsigned FB_W  = EST_W + COEF_W + GAIN_FRAC;
  localparam int unsigned ACC_W = ((FWD_W > FB_W) ? FWD_W : FB_W) + 2;
  localparam int unsigned FRAC  = COEF_FRAC + GAIN_FRAC;
  localparam logic signed [ACC_W-1:0] OMAX = (ACC_W'(1) <<< (EST_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] OMIN = ~OMAX;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);

  logic signed [IN_W-1:0]  x_prev;
  logic signed [SUM_W-1:0] x_sum;
  logic signed [SCL_W-1:0] scaled;
  logic signed [ACC_W-1:0] fwd, fb, acc, rnd, q;
  logic signed [EST_W-1:0] y_next;

  assign x_sum  = SUM_W'(x_in) + SUM_W'(x_prev);
  assign scaled = SCL_W'(x_sum) * SCL_W'(gain_g);
  assign fwd    = ACC_W'(scaled) * ACC_W'(coef_in);
  // align feedback product to the COEF_FRAC+GAIN_FRAC scale of the input path
  assign fb     = (ACC_W'(est_out) * ACC_W'(coef_fb)) <<< GAIN_FRAC;
  assign acc    = fwd + fb;
  assign rnd    = acc + HALF;
  assign q      = rnd >>> FRAC;

  always_comb begin
    if (q > OMAX)      y_next = OMAX[EST_W-1:0];
    else if (q < OMIN) y_next = OMIN[EST_W-1:0];
    else               y_next = q[EST_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_prev    <= '0;
      est_out   <= '0;
      est_valid <= 1'b0;
    end else begin
      est_valid <= in_valid;
      if (in_valid) begin
        est_out <= y_next;
        x_prev  <= x_in;
      end
    end
  end

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> est_valid);
  assert_valid_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !est_valid);
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(est_out));
  assert_state_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (est_out == '0 && x_prev == '0 && !est_valid));
endmodule

// File: rtl/ind_cur_est.sv
module ind_cur_est
  import ind_est_pkg::*;
#(
  parameter int unsigned DUTY_W    = DEF_DUTY_W,
  parameter int unsigned VCODE_W   = DEF_VCODE_W,
  parameter int unsigned COEF_W    = DEF_COEF_W,
  parameter int unsigned COEF_FRAC = DEF_COEF_FRAC,
  parameter int unsigned GAIN_W    = DEF_GAIN_W,
  parameter int unsigned GAIN_FRAC = DEF_GAIN_FRAC,
  parameter int unsigned EST_W     = DEF_EST_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cyc_strobe,
  input  logic [DUTY_W-1:0]        duty_cmd,
  input  logic [VCODE_W-1:0]       vout_code,
  input  logic                     vin_load,
  input  logic [VCODE_W-1:0]       vin_code,
  input  logic signed [COEF_W-1:0] coef_fb,
  input  logic signed [COEF_W-1:0] coef_in,
  input  logic signed [GAIN_W-1:0] gain_g,
  output logic                     est_valid,
  output logic signed [EST_W-1:0]  est_cur
);
  localparam int unsigned VL_W = VCODE_W + 1;

  logic [VCODE_W-1:0]      vin_eff;
  logic signed [VL_W-1:0]  vl_avg;
  logic                    vl_valid;
  logic signed [COEF_W-1:0] fb_sh, in_sh;
  logic signed [GAIN_W-1:0] g_sh;

  est_vin_hold #(.VCODE_W(VCODE_W)) u_vin (
    .clk(clk), .rst(rst), .vin_load(vin_load), .vin_code(vin_code), .vin_eff(vin_eff)
  );

  est_avg_volt #(.DUTY_W(DUTY_W), .VCODE_W(VCODE_W)) u_avg (
    .clk(clk), .rst(rst), .strobe(cyc_strobe), .duty(duty_cmd), .vin_eff(vin_eff),
    .vout_code(vout_code), .vl_avg(vl_avg), .vl_valid(vl_valid)
  );

  // coefficient snapshot taken at the cycle boundary only
  always_ff @(posedge clk) begin
    if (rst) begin
      fb_sh <= '0;
      in_sh <= '0;
      g_sh  <= '0;
    end else if (cyc_strobe) begin
      fb_sh <= coef_fb;
      in_sh <= coef_in;
      g_sh  <= gain_g;
    end
  end

  est_iir_core #(
    .IN_W(VL_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
    .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .EST_W(EST_W)
  ) u_iir (
    .clk(clk), .rst(rst), .in_valid(vl_valid), .x_in(vl_avg),
    .coef_fb(fb_sh), .coef_in(in_sh), .gain_g(g_sh),
    .est_valid(est_valid), .est_out(est_cur)
  );

  assert_coef_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    !cyc_strobe |=> ($stable(fb_sh) && $stable(in_sh) && $stable(g_sh)));
  assert_coef_take_R9: assert property (@(posedge clk) disable iff (rst)
    cyc_strobe |=> (fb_sh == $past(coef_fb) && in_sh == $past(coef_in) && g_sh == $past(gain_g)));
endmodule

// File: tb/ind_cur_est_bench.sv
`timescale 1ns/1ps
module ind_cur_est_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_strobe = 1'b0;
  logic [7:0] duty_cmd = '0;
  logic [9:0] vout_code = '0;
  logic vin_load = 1'b0;
  logic [9:0] vin_code = '0;
  logic signed [15:0] coef_fb = '0, coef_in = '0, gain_g = '0;
  logic est_valid;
  logic signed [15:0] est_cur;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int cur_c1 = 0, cur_c2 = 0, cur_g = 0;
  longint m_vin = 0, m_vp = 0, m_yp = 0;

  always #2.5 clk = ~clk;

  ind_cur_est u_ind_cur_est (
    .clk(clk), .rst(rst), .cyc_strobe(cyc_strobe), .duty_cmd(duty_cmd),
    .vout_code(vout_code), .vin_load(vin_load), .vin_code(vin_code),
    .coef_fb(coef_fb), .coef_in(coef_in), .gain_g(gain_g),
    .est_valid(est_valid), .est_cur(est_cur)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_coef(int c1, int c2, int g);
    cur_c1 = c1; cur_c2 = c2; cur_g = g;
    coef_fb = 16'(c1); coef_in = 16'(c2); gain_g = 16'(g);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_vin = 0; m_vp = 0; m_yp = 0;
  endtask

  // reference from R3..R6, computed with the coefficients present at the strobe
  task automatic model(int d, int vo, bit vv, int vin, output longint y);
    longint va, acc, q;
    if (vv) m_vin = vin;
    va  = ((longint'(d) * m_vin) >>> 8) - vo;
    acc = longint'(cur_c1) * m_yp * 256 + longint'(cur_c2) * cur_g * (va + m_vp);
    q   = (acc + (longint'(1) <<< 21)) >>> 22;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    m_vp = va; m_yp = q; y = q;
  endtask

  // called at a negedge; optionally swaps coefficients between strobe and result
  task automatic run_cycle(int d, int vo, bit vv, int vin, string tag,
                           bit swap = 1'b0, int n1 = 0, int n2 = 0, int ng = 0,
                           output longint y);
    model(d, vo, vv, vin, y);
    duty_cmd = 8'(d); vout_code = 10'(vo); vin_load = vv;
    vin_code = vv ? 10'(vin) : 10'((vin + 333) % 1024);
    cyc_strobe = 1'b1;
    @(negedge clk);
    cyc_strobe = 1'b0; vin_load = 1'b0;
    vin_code = 10'((vin * 7 + 91) % 1024);
    chk("R7 valid low one clock after strobe", longint'(est_valid), 0);
    if (swap) set_coef(n1, n2, ng);
    @(negedge clk);
    chk("R7 valid two clocks after strobe", longint'(est_valid), 1);
    chk(tag, longint'(est_cur), y);
  endtask

  initial begin
    longint y, held;
    do_reset();
    chk("R1 reset est_valid", longint'(est_valid), 0);
    chk("R1 reset est_cur", longint'(est_cur), 0);

    // R3 sweep of every duty code with c1=0, c2=1.0, g=1.0
    set_coef(0, 16384, 256);
    for (int d = 0; d < 256; d++)
      run_cycle(d, (d * 3) % 1024, (d % 10) == 0, 1023 - d * 2, "R3 avg voltage sweep", .y(y));

    // R2 hold of input sample across ten cycles, junk on vin_code
    do_reset();
    run_cycle(128, 100, 1'b1, 700, "R2 sample with strobe", .y(y));
    chk("R2 same-clock sample used", y, 250 + 0);
    for (int k = 0; k < 9; k++) run_cycle(64 + k * 16, 50, 1'b0, 5 * k, "R2 held input", .y(y));

    // R7 output holds after the pulse
    held = est_cur;
    @(negedge clk);
    chk("R7 valid returns low", longint'(est_valid), 0);
    chk("R7 estimate holds", longint'(est_cur), held);

    // R5 rounding of +-0.5
    do_reset();
    set_coef(0, 16384, 128);
    run_cycle(255, 254, 1'b1, 256, "R5 round", .y(y));
    chk("R5 +0.5 rounds to 1", longint'(est_cur), 1);
    run_cycle(255, 257, 1'b0, 0, "R5 round", .y(y));
    chk("R5 -0.5 rounds to 0", longint'(est_cur), 0);

    // R6 saturation both ways
    do_reset();
    set_coef(0, 16384, 32767);
    run_cycle(255, 0, 1'b1, 1023, "R6 sat", .y(y));
    chk("R6 positive saturation", longint'(est_cur), 32767);
    run_cycle(0, 1023, 1'b0, 0, "R6 sat", .y(y));
    run_cycle(0, 1023, 1'b0, 0, "R6 sat", .y(y));
    chk("R6 negative saturation", longint'(est_cur), -32768);

    // R8 coefficient change between strobe and result, R9 used next cycle
    do_reset();
    set_coef(8192, 16384, 256);
    run_cycle(200, 100, 1'b1, 600, "R8 old coefficients used", 1'b1, -4000, 9000, 700, y);
    run_cycle(150, 120, 1'b0, 0, "R9 new coefficients with kept state", .y(y));
    run_cycle(150, 120, 1'b0, 0, "R9 new coefficients with kept state", .y(y));

    // R4 random coefficients and inputs
    for (int k = 0; k < 300; k++) begin
      if (k % 25 == 0)
        set_coef(int'($urandom_range(32767)) - 16384, int'($urandom_range(16383)),
                 int'($urandom_range(1023)));
      run_cycle(int'($urandom_range(255)), int'($urandom_range(1023)), (k % 10) == 0,
                int'($urandom_range(1023)), "R4 recursion", .y(y));
    end

    // R1 reset mid-run clears held input and filter state
    set_coef(16000, 16384, 256);
    run_cycle(255, 10, 1'b1, 900, "R1 before reset", .y(y));
    do_reset();
    chk("R1 mid-run reset est_cur", longint'(est_cur), 0);
    run_cycle(200, 5, 1'b0, 0, "R1 cleared state", .y(y));
    chk("R1 first estimate after reset", longint'(est_cur), -5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule